// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects up to 128 level-sensitive interrupt lines, grouped in banks of 32, and presents them to one processor through a single interrupt output. Software reaches the controller through a plain 32-bit register port: one write channel and one read channel that returns data combinationally. Each bank has a mask register, two write-only aliases that set or clear individual mask bits, and a read-only view of the sources that are both asserted and enabled.

When the controller is idle and any enabled source is pending, it latches the number of the lowest-numbered pending source into an active-number register and raises the interrupt output. Both stay unchanged until software writes an acknowledge. After the acknowledge the controller chooses again from whatever is pending at that time. A soft-reset command puts the mask and active state back to their reset values over a fixed number of cycles and reports completion through a status bit.

The controller also has a revision register, an autoidle flag, a threshold register and one level register per source. These hold what software writes to them and affect nothing else.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After hardware reset every mask bit reads 1, the active number at 0x040 reads 0, the output `irq_out` is low, status 0x014 bit 0 reads 1 and configuration 0x010 reads 0.
- R2: A write to 0x088 + 0x20*n clears the mask bits of bank n where the written data has a 1. Bits written as 0 keep their value. The mask of bank n reads at 0x084 + 0x20*n.
- R3: A write to 0x08C + 0x20*n sets the mask bits of bank n where the written data has a 1. Bits written as 0 keep their value.
- R4: The read-only register at 0x098 + 0x20*n returns source AND NOT mask for bank n, with no clock delay.
- R5: When no interrupt is active and at least one enabled source is pending at a clock edge, that edge latches the lowest-numbered pending source into bits 6:0 of 0x040 and drives `irq_out` high.
- R6: While `irq_out` is high, the active number and `irq_out` keep their values until an acknowledge. This holds even if the active source drops or a lower-numbered source becomes pending.
- R7: A write to 0x048 with bit 0 set is an acknowledge. It drives `irq_out` low at that edge, and the next edge runs the R5 selection again. A write to 0x048 with bit 0 clear has no effect.
- R8: A write to 0x010 with bit 1 set starts a soft reset that lasts 4 cycles. During those cycles 0x014 bit 0 reads 0, 0x010 bit 1 reads 1, all masks read 1, the active number reads 0 and `irq_out` is low. After the 4th edge bit 1 has cleared itself and the status bit reads 1 again.
- R9: Mask writes made while a soft reset is in progress have no effect.
- R10: Bit 0 of 0x010 is an autoidle flag that reads back the last value written, including 0. A soft reset does not change it.
- R11: The register at 0x000 returns the major revision in bits 7:4 and the minor revision in bits 3:0. With the default parameters it reads 0x21.
- R12: The threshold register at 0x068 and the level register of source i at 0x100 + 4*i read back the full 32-bit value written. A soft reset does not change them; only hardware reset clears them.
- R13: Bank registers beyond the configured source count, and level addresses at or above 0x100 + 4*NUM_SRC, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| src_lvl | input | NUM_SRC | Level-sensitive interrupt source lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The two functions most likely to collide are the acknowledge write and a change on the source lines in the same clock cycle. In one case the bench drops the active source and acknowledges at the same edge, while a different unmasked source is already pending. The bench expects `irq_out` low straight after the acknowledge edge and the other source latched one edge later, with the lowest pending number winning. A second collision is a mask write issued during a soft reset: after the reset finishes, the mask must read all ones.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   timeunit 1ns;
   timeprecision 10ps;

   localparam int unsigned BANK_W        = 32;
   localparam int unsigned ACT_W         = 7;

   localparam int unsigned OFS_REV       = 32'h000;
   localparam int unsigned OFS_SYSCFG    = 32'h010;
   localparam int unsigned OFS_SYSSTAT   = 32'h014;
   localparam int unsigned OFS_ACTIVE    = 32'h040;
   localparam int unsigned OFS_CTRL      = 32'h048;
   localparam int unsigned OFS_THRESH    = 32'h068;
   localparam int unsigned OFS_BANK_BASE = 32'h080;
   localparam int unsigned BANK_STRIDE   = 32'h020;
   localparam int unsigned SUB_MASK      = 32'h04;
   localparam int unsigned SUB_CLR       = 32'h08;
   localparam int unsigned SUB_SET       = 32'h0C;
   localparam int unsigned SUB_PEND      = 32'h18;
   localparam int unsigned OFS_LVL0      = 32'h100;

   typedef enum logic [3:0] {
      RK_NONE,
      RK_REV,
      RK_SYSCFG,
      RK_SYSSTAT,
      RK_ACTIVE,
      RK_CTRL,
      RK_THRESH,
      RK_MASK,
      RK_MCLR,
      RK_MSET,
      RK_PEND,
      RK_LVL
   } reg_kind_e;
endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
   import irqc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_SRC   = 96,
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned BK_W      = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind,
   output logic [BK_W-1:0]   bank,
   output logic [IDX_W-1:0]  idx
);
   timeunit 1ns;
   timeprecision 10ps;

   localparam int unsigned BANK_SPAN = BANK_STRIDE * NUM_BANKS;
   localparam int unsigned LVL_SPAN  = 4 * NUM_SRC;

   always_comb begin
      int unsigned a;
      int unsigned rel;
      a    = 32'(addr);
      rel  = 0;
      kind = RK_NONE;
      bank = '0;
      idx  = '0;
      if (a == OFS_REV) begin
         kind = RK_REV;
      end else if (a == OFS_SYSCFG) begin
         kind = RK_SYSCFG;
      end else if (a == OFS_SYSSTAT) begin
         kind = RK_SYSSTAT;
      end else if (a == OFS_ACTIVE) begin
         kind = RK_ACTIVE;
      end else if (a == OFS_CTRL) begin
         kind = RK_CTRL;
      end else if (a == OFS_THRESH) begin
         kind = RK_THRESH;
      end else if (a >= OFS_BANK_BASE && a < OFS_BANK_BASE + BANK_SPAN) begin
         rel  = a - OFS_BANK_BASE;
         bank = BK_W'(rel / BANK_STRIDE);
         case (rel % BANK_STRIDE)
            SUB_MASK: kind = RK_MASK;
            SUB_CLR:  kind = RK_MCLR;
            SUB_SET:  kind = RK_MSET;
            SUB_PEND: kind = RK_PEND;
            default:  kind = RK_NONE;
         endcase
      end else if (a >= OFS_LVL0 && a < OFS_LVL0 + LVL_SPAN && a[1:0] == 2'b00) begin
         kind = RK_LVL;
         idx  = IDX_W'((a - OFS_LVL0) >> 2);
      end
   end
endmodule

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] wbits,
   input  logic [WIDTH-1:0] src,
   output logic [WIDTH-1:0] mask_q,
   output logic [WIDTH-1:0] pend
);
   timeunit 1ns;
   timeprecision 10ps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (hold) begin
         mask_q <= '1;
      end else if (set_we) begin
         mask_q <= mask_q | wbits;
      end else if (clr_we) begin
         mask_q <= mask_q & ~wbits;
      end
   end

   assign pend = src & ~mask_q;
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
   parameter int unsigned N     = 96,
   parameter int unsigned IDX_W = 7
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   timeunit 1ns;
   timeprecision 10ps;

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irqc_srst_seq.sv
module irqc_srst_seq #(
   parameter int unsigned CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   timeunit 1ns;
   timeprecision 10ps;

   localparam int unsigned CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CNT_W'(CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 96,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SRST_CYCLES = 4,
   parameter int unsigned REV_MAJOR   = 2,
   parameter int unsigned REV_MINOR   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   output logic               irq_out
);
   timeunit 1ns;
   timeprecision 10ps;

   localparam int unsigned NUM_BANKS = NUM_SRC / BANK_W;
   localparam int unsigned IDX_W     = $clog2(NUM_SRC);
   localparam int unsigned BK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   if (NUM_SRC % BANK_W != 0 || NUM_SRC < BANK_W || NUM_SRC > 128) begin : g_bad_src
      $error("irq_bank_ctrl: NUM_SRC must be a multiple of 32 in 32..128");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("irq_bank_ctrl: DATA_W must be 32");
   end
   if (ADDR_W < 10 || ADDR_W > 31) begin : g_bad_addr
      $error("irq_bank_ctrl: ADDR_W must be in 10..31");
   end
   if (SRST_CYCLES < 1) begin : g_bad_srst
      $error("irq_bank_ctrl: SRST_CYCLES must be at least 1");
   end
   if (REV_MAJOR > 15 || REV_MINOR > 15) begin : g_bad_rev
      $error("irq_bank_ctrl: revision fields are 4 bits");
   end

   reg_kind_e         wk, rk;
   logic [BK_W-1:0]   wbank, rbank;
   logic [IDX_W-1:0]  widx, ridx;

   irqc_addr_dec #(
      .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_BANKS(NUM_BANKS),
      .IDX_W(IDX_W), .BK_W(BK_W)
   ) u_wdec (
      .addr(wr_addr), .kind(wk), .bank(wbank), .idx(widx)
   );

   irqc_addr_dec #(
      .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_BANKS(NUM_BANKS),
      .IDX_W(IDX_W), .BK_W(BK_W)
   ) u_rdec (
      .addr(rd_addr), .kind(rk), .bank(rbank), .idx(ridx)
   );

   logic srst_start, srst_busy, hold;
   logic ack_wr;
   logic autoidle_q;

   assign srst_start = wr_en && (wk == RK_SYSCFG) && wr_data[1];
   assign ack_wr     = wr_en && (wk == RK_CTRL) && wr_data[0];
   assign hold       = srst_start || srst_busy;

   irqc_srst_seq #(.CYCLES(SRST_CYCLES)) u_srst (
      .clk(clk), .rst_n(rst_n), .start(srst_start), .busy(srst_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         autoidle_q <= 1'b0;
      end else if (wr_en && wk == RK_SYSCFG) begin
         autoidle_q <= wr_data[0];
      end
   end

   logic [BANK_W-1:0]  mask_bk [NUM_BANKS];
   logic [BANK_W-1:0]  pend_bk [NUM_BANKS];
   logic [NUM_SRC-1:0] mask_flat, pend_flat;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic set_we, clr_we;
      assign set_we = wr_en && (wk == RK_MSET) && (wbank == BK_W'(b));
      assign clr_we = wr_en && (wk == RK_MCLR) && (wbank == BK_W'(b));

      irqc_mask_bank #(.WIDTH(BANK_W)) u_mask (
         .clk(clk), .rst_n(rst_n), .hold(hold),
         .set_we(set_we), .clr_we(clr_we), .wbits(wr_data),
         .src(src_lvl[b*BANK_W +: BANK_W]),
         .mask_q(mask_bk[b]), .pend(pend_bk[b])
      );

      assign mask_flat[b*BANK_W +: BANK_W] = mask_bk[b];
      assign pend_flat[b*BANK_W +: BANK_W] = pend_bk[b];
   end

   logic             pend_any;
   logic [IDX_W-1:0] win_idx;

   irqc_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .req(pend_flat), .any(pend_any), .idx(win_idx)
   );

   logic             busy_q;
   logic [ACT_W-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         act_q  <= '0;
      end else if (hold) begin
         busy_q <= 1'b0;
         act_q  <= '0;
      end else if (ack_wr) begin
         busy_q <= 1'b0;
      end else if (!busy_q && pend_any) begin
         busy_q <= 1'b1;
         act_q  <= ACT_W'(win_idx);
      end
   end

   assign irq_out = busy_q;

   logic [DATA_W-1:0] thresh_q;
   logic [DATA_W-1:0] lvl_q [NUM_SRC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thresh_q <= '0;
         for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
      end else if (wr_en) begin
         if (wk == RK_THRESH) thresh_q <= wr_data;
         if (wk == RK_LVL) lvl_q[widx] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rk)
         RK_REV:     rd_data = DATA_W'({4'(REV_MAJOR), 4'(REV_MINOR)});
         RK_SYSCFG:  rd_data = DATA_W'({srst_busy, autoidle_q});
         RK_SYSSTAT: rd_data = DATA_W'(!srst_busy);
         RK_ACTIVE:  rd_data = DATA_W'(act_q);
         RK_THRESH:  rd_data = thresh_q;
         RK_MASK:    rd_data = mask_bk[rbank];
         RK_PEND:    rd_data = pend_bk[rbank];
         RK_LVL:     rd_data = lvl_q[ridx];
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
   parameter int unsigned NUM_SRC = 96,
   parameter int unsigned ACT_W   = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_out,
   input logic               ack_wr,
   input logic               srst_start,
   input logic               srst_busy,
   input logic [ACT_W-1:0]   act_q,
   input logic               pend_any,
   input logic [NUM_SRC-1:0] mask_flat
);
   timeunit 1ns;
   timeprecision 10ps;

   // R5: the output only rises after an enabled source was pending
   a_r5_rise_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(pend_any));

   // R5: an idle controller with a pending source takes it at the next edge
   a_r5_idle_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out && pend_any && !srst_start && !srst_busy && !ack_wr) |=> irq_out);

   // R6: active number and request are held until acknowledge
   a_r6_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !ack_wr && !srst_start) |=> (irq_out && $stable(act_q)));

   // R7: acknowledge drops the request at once
   a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> !irq_out);

   // R8: soft reset holds the reset state
   a_r8_srst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      srst_busy |-> (!irq_out && (&mask_flat) && act_q == '0));

   // R8: a soft-reset command enters the busy window
   a_r8_srst_enters: assert property (@(posedge clk) disable iff (!rst_n)
      srst_start |=> srst_busy);
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(.NUM_SRC(NUM_SRC), .ACT_W(7)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .ack_wr(ack_wr),
   .srst_start(srst_start), .srst_busy(srst_busy), .act_q(act_q),
   .pend_any(pend_any), .mask_flat(mask_flat)
);

// File: tb/irq_bank_ctrl_tb_top.sv
module irq_bank_ctrl_tb_top;
   timeunit 1ns;
   timeprecision 10ps;

   localparam int NS = 96;
   localparam int AW = 12;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          irq_out;

   always #2.5 clk = ~clk;

   irq_bank_ctrl #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_lvl(src),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [31:0]   q_exp  [$];
   int            q_kind [$];
   logic [AW-1:0] q_addr [$];
   string         q_tag  [$];
   event push_ev, pop_ev;

   // scoreboard monitor
   initial begin
      forever begin
         logic [31:0] e, act;
         int k;
         logic [AW-1:0] a;
         string t;
         @(push_ev);
         #0.1;
         e = q_exp.pop_front();
         k = q_kind.pop_front();
         a = q_addr.pop_front();
         t = q_tag.pop_front();
         act = (k == 0) ? rd_data : {31'b0, irq_out};
         n_tests++;
         if (act !== e) begin
            n_fail++;
            $display("FAIL %s (%s addr=0x%03h) actual=0x%08h expected=0x%08h",
                     t, (k == 0) ? "read" : "irq", a, act, e);
         end
         ->pop_ev;
      end
   end

   task automatic chk_rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
      rd_addr = a;
      q_exp.push_back(e);
      q_kind.push_back(0);
      q_addr.push_back(a);
      q_tag.push_back(t);
      ->push_ev;
      @(pop_ev);
   endtask

   task automatic chk_irq(input logic e, input string t);
      q_exp.push_back({31'b0, e});
      q_kind.push_back(1);
      q_addr.push_back('0);
      q_tag.push_back(t);
      ->push_ev;
      @(pop_ev);
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      chk_rd(12'h084, 32'hFFFF_FFFF, "R1 mask bank0");
      chk_rd(12'h0A4, 32'hFFFF_FFFF, "R1 mask bank1");
      chk_rd(12'h0C4, 32'hFFFF_FFFF, "R1 mask bank2");
      chk_rd(12'h040, 32'h0, "R1 active number");
      chk_irq(1'b0, "R1 irq low");
      chk_rd(12'h014, 32'h1, "R1 reset done status");
      chk_rd(12'h010, 32'h0, "R1 config");
      // R11 revision
      chk_rd(12'h000, 32'h21, "R11 revision");
      // R13 absent bank and level range
      bus_wr(12'h0E8, 32'hFFFF_FFFF);
      bus_wr(12'h280, 32'h1234_0000);
      chk_rd(12'h0E4, 32'h0, "R13 absent mask");
      chk_rd(12'h0F8, 32'h0, "R13 absent pending");
      chk_rd(12'h280, 32'h0, "R13 level past range");

      // R2 clear alias
      bus_wr(12'h088, 32'h5);
      chk_rd(12'h084, 32'hFFFF_FFFA, "R2 clear ones");
      bus_wr(12'h088, 32'h0);
      chk_rd(12'h084, 32'hFFFF_FFFA, "R2 zero bits no effect");
      // R3 set alias
      bus_wr(12'h08C, 32'h1);
      chk_rd(12'h084, 32'hFFFF_FFFB, "R3 set ones");

      // R4 pending view
      src[0] = 1'b1; src[2] = 1'b1; src[40] = 1'b1;
      chk_rd(12'h098, 32'h4, "R4 pending bank0");
      chk_rd(12'h0B8, 32'h0, "R4 pending bank1 masked");
      chk_irq(1'b0, "R5 no request before edge");
      tick(1);
      chk_irq(1'b1, "R5 request raised");
      chk_rd(12'h040, 32'h2, "R5 lowest pending latched");

      // R6 hold while other sources change
      src[1] = 1'b1; src[2] = 1'b0;
      bus_wr(12'h088, 32'h2);
      chk_rd(12'h040, 32'h2, "R6 active held");
      chk_irq(1'b1, "R6 irq held");
      chk_rd(12'h098, 32'h2, "R4 pending after change");

      // R7 acknowledge
      bus_wr(12'h048, 32'h0);
      chk_irq(1'b1, "R7 zero write ignored");
      chk_rd(12'h040, 32'h2, "R7 zero write keeps active");
      bus_wr(12'h048, 32'h1);
      chk_irq(1'b0, "R7 ack drops irq");
      tick(1);
      chk_irq(1'b1, "R7 reselect after ack");
      chk_rd(12'h040, 32'h1, "R7 next source 1");

      // collision: source drop and ack at the same edge
      bus_wr(12'h0A8, 32'h100);
      chk_rd(12'h040, 32'h1, "R6 active held after unmask");
      src[1] = 1'b0;
      bus_wr(12'h048, 32'h1);
      chk_irq(1'b0, "R7 ack with source drop");
      tick(1);
      chk_rd(12'h040, 32'h28, "R5 bank1 source 40 selected");
      chk_irq(1'b1, "R5 irq for source 40");

      src[70] = 1'b1;
      bus_wr(12'h0C8, 32'h40);
      bus_wr(12'h0AC, 32'h100);
      chk_rd(12'h0D8, 32'h40, "R4 pending bank2");
      bus_wr(12'h048, 32'h1);
      chk_irq(1'b0, "R7 ack before source 70");
      tick(1);
      chk_rd(12'h040, 32'h46, "R5 source 70 selected");
      chk_irq(1'b1, "R5 irq for source 70");

      // R10 autoidle
      bus_wr(12'h010, 32'h1);
      chk_rd(12'h010, 32'h1, "R10 autoidle set");
      bus_wr(12'h010, 32'h0);
      chk_rd(12'h010, 32'h0, "R10 autoidle cleared");
      bus_wr(12'h010, 32'h1);

      // R12 storage
      bus_wr(12'h068, 32'hA5A5_0003);
      bus_wr(12'h100, 32'h1234_5678);
      bus_wr(12'h27C, 32'hCAFE_0001);
      chk_rd(12'h068, 32'hA5A5_0003, "R12 threshold");
      chk_rd(12'h100, 32'h1234_5678, "R12 level 0");
      chk_rd(12'h27C, 32'hCAFE_0001, "R12 level 95");
      chk_rd(12'h104, 32'h0, "R12 level 1 untouched");

      // R8 soft reset
      bus_wr(12'h010, 32'h3);
      chk_rd(12'h014, 32'h0, "R8 status busy");
      chk_rd(12'h010, 32'h3, "R8 reset bit visible");
      chk_irq(1'b0, "R8 irq cleared");
      chk_rd(12'h040, 32'h0, "R8 active cleared");
      chk_rd(12'h0C4, 32'hFFFF_FFFF, "R8 masks set");
      // R9 write during soft reset
      bus_wr(12'h088, 32'hFFFF_FFFF);
      chk_rd(12'h084, 32'hFFFF_FFFF, "R9 mask write ignored");
      chk_rd(12'h014, 32'h0, "R8 still busy");
      tick(2);
      chk_rd(12'h014, 32'h0, "R8 busy in 4th cycle");
      tick(1);
      chk_rd(12'h014, 32'h1, "R8 done after 4 cycles");
      chk_rd(12'h010, 32'h1, "R8 reset bit self-clear, R10 kept");
      chk_rd(12'h084, 32'hFFFF_FFFF, "R9 mask still set after reset");
      chk_irq(1'b0, "R8 irq low after reset");
      chk_rd(12'h068, 32'hA5A5_0003, "R12 threshold survives");
      chk_rd(12'h27C, 32'hCAFE_0001, "R12 level survives");

      bus_wr(12'h0C8, 32'h40);
      tick(1);
      chk_irq(1'b1, "R5 irq after re-enable");
      chk_rd(12'h040, 32'h46, "R5 source 70 again");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule